// File: doc/BRIEF.md
# Preset Fader and Output Scaler

This block sits after a stereo convolution engine and decides which coefficient preset is in force and how the filtered sum is scaled. It takes a three-bit preset code and a two-bit shift code either from board strap inputs or from a value held in a serial control register, chosen by a single source-select input. Six preset codes name built-in speaker/virtual angle pairs, one names the downloaded coefficient set, and one bypasses the effect so that the unprocessed (dry) stereo input is passed through.

A preset change is never applied in one step. When the requested preset differs from the one in force, a gain applied to both output channels ramps down linearly one step per sample, the reported preset index changes only while the gain sits at zero, and the gain then ramps back to full scale. The filtered sum is arithmetically right-shifted by the selected amount, multiplied by the fade gain and saturated to the output width. Outputs are registered and move only on a sample strobe.

Top module: `preset_fade_scaler`

## Requirements
- R1: With `src_sel` = 0 the requested preset and shift come from `strap_preset`/`strap_shift`; with `src_sel` = 1 they come from `reg_preset`/`reg_shift`.
- R2: Preset codes 0 to 6 (0..5 built-in pairs, 6 the downloaded set) output the shifted filtered sample; code 7 outputs the dry sample with no shift, scaled only by the gain.
- R3: Shift code n (0..3) applies an arithmetic right shift of n bits to the filtered sample (rounding toward minus infinity) before the gain.
- R4: Each output equals floor(s * g / RAMP_STEPS) saturated to the signed DW-bit range, never wrapping, where s is the selected sample and g the gain (0..RAMP_STEPS).
- R5: When the requested preset differs from the active one, the gain drops by one per strobe from full scale; on the strobe at which the gain is zero the active preset takes the requested value; the gain then rises by one per strobe back to full scale (RAMP_STEPS = 64 steps each way). `active_preset` changes only when the gain is zero.
- R6: A request change during fade-out is not applied early; the value requested at the zero-gain strobe is applied. A request that differs from the active preset during fade-in turns the ramp back downward from the current gain (or, at zero gain, is applied at once).
- R7: Synchronous active-low reset sets the gain to full scale, the active preset to the currently requested value, and both outputs to 0.
- R8: Outputs and `active_preset` change only on a clock edge where `smp_stb` is 1; each output update uses the gain and preset in force before that strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_sel | input | 1 | 0: straps, 1: control register |
| strap_preset | input | 3 | Preset code from straps |
| strap_shift | input | 2 | Shift code from straps |
| reg_preset | input | 3 | Preset code from control register |
| reg_shift | input | 2 | Shift code from control register |
| smp_stb | input | 1 | One-cycle sample strobe |
| wet_l | input | SUM_W | Left filtered sum, signed |
| wet_r | input | SUM_W | Right filtered sum, signed |
| dry_l | input | DW | Left unprocessed sample, signed |
| dry_r | input | DW | Right unprocessed sample, signed |
| out_l | output | DW | Left result, signed |
| out_r | output | DW | Right result, signed |
| active_preset | output | 3 | Preset code in force |

## Verification
The scaler is swept over every shift code with pseudo-random and extreme filtered sums, including full-scale positive and negative values that separate saturation from wrapping and floor rounding from truncation. Complete fade sequences are run with the request changed once, changed again mid fade-out and reversed mid fade-in, so each strobe's output reveals whether the gain steps by one and when the preset swaps. Bypass and the downloaded preset are entered through a fade to tell the dry path from the filtered path, and both sources are swapped to show that only the selected one is heard.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
    typedef enum logic [1:0] {
        PH_HOLD = 2'd0,
        PH_DOWN = 2'd1,
        PH_UP   = 2'd2
    } phase_e;

    localparam logic [2:0] PRESET_BYPASS = 3'b111;
endpackage

// File: rtl/pfs_src_select.sv
module pfs_src_select (
    input  logic       src_sel,
    input  logic [2:0] strap_preset,
    input  logic [1:0] strap_shift,
    input  logic [2:0] reg_preset,
    input  logic [1:0] reg_shift,
    output logic [2:0] want_preset,
    output logic [1:0] want_shift
);
    // R1: straps when low, control register when high
    always_comb begin
        if (src_sel) begin
            want_preset = reg_preset;
            want_shift  = reg_shift;
        end else begin
            want_preset = strap_preset;
            want_shift  = strap_shift;
        end
    end
endmodule

// File: rtl/pfs_fade_ctrl.sv
module pfs_fade_ctrl
    import pfs_pkg::*;
#(
    parameter int RAMP_STEPS = 64,
    parameter int GAIN_W     = $clog2(RAMP_STEPS) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_stb,
    input  logic [2:0]        want_preset,
    output logic [2:0]        active_preset,
    output logic [GAIN_W-1:0] gain,
    output phase_e            phase
);
    localparam logic [GAIN_W-1:0] FULL = GAIN_W'(RAMP_STEPS);
    localparam logic [GAIN_W-1:0] ONE  = GAIN_W'(1);

    typedef struct packed {
        phase_e            phase;
        logic [GAIN_W-1:0] gain;
        logic [2:0]        active;
    } fade_st_t;

    fade_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            // R7: full gain, preset taken from the selected source
            st_d.phase  = PH_HOLD;
            st_d.gain   = FULL;
            st_d.active = want_preset;
        end else if (smp_stb) begin
            unique case (st_q.phase)
                PH_HOLD: begin
                    if (want_preset != st_q.active) begin
                        st_d.phase = PH_DOWN;
                        st_d.gain  = st_q.gain - ONE;
                    end
                end
                PH_DOWN: begin
                    // R5/R6: swap only once the gain has reached zero
                    if (st_q.gain == '0) begin
                        st_d.active = want_preset;
                        st_d.phase  = PH_UP;
                    end else begin
                        st_d.gain = st_q.gain - ONE;
                    end
                end
                PH_UP: begin
                    if (want_preset != st_q.active) begin
                        // R6: reverse the ramp
                        if (st_q.gain == '0) begin
                            st_d.active = want_preset;
                        end else begin
                            st_d.phase = PH_DOWN;
                            st_d.gain  = st_q.gain - ONE;
                        end
                    end else begin
                        st_d.gain = st_q.gain + ONE;
                        if (st_q.gain == FULL - ONE) begin
                            st_d.phase = PH_HOLD;
                        end
                    end
                end
                default: st_d.phase = PH_HOLD;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign active_preset = st_q.active;
    assign gain          = st_q.gain;
    assign phase         = st_q.phase;
endmodule

// File: rtl/pfs_chan.sv
module pfs_chan #(
    parameter int DW        = 16,
    parameter int SUM_W     = 18,
    parameter int GAIN_W    = 7,
    parameter int RAMP_LOG2 = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_stb,
    input  logic signed [SUM_W-1:0] wet,
    input  logic signed [DW-1:0]    dry,
    input  logic                    bypass,
    input  logic [1:0]              shift,
    input  logic [GAIN_W-1:0]       gain,
    output logic signed [DW-1:0]    y
);
    localparam int PW = SUM_W + GAIN_W + 1;
    localparam logic signed [PW-1:0] HI = (PW'(1) <<< (DW - 1)) - PW'(1);
    localparam logic signed [PW-1:0] LO = ~HI;

    logic signed [SUM_W-1:0] src;
    logic signed [PW-1:0]    prod;
    logic signed [PW-1:0]    scaled;
    logic signed [DW-1:0]    y_d, y_q;

    always_comb begin
        // R2: dry path for bypass, R3: shifted filtered path otherwise
        if (bypass) src = SUM_W'(dry);
        else        src = wet >>> shift;
        prod   = PW'(src) * PW'($signed({1'b0, gain}));
        scaled = prod >>> RAMP_LOG2;
        // R4: clamp instead of wrapping
        if (scaled > HI)      y_d = HI[DW-1:0];
        else if (scaled < LO) y_d = LO[DW-1:0];
        else                  y_d = scaled[DW-1:0];
        if (!rst_n)           y_d = '0;
        else if (!smp_stb)    y_d = y_q;
    end

    always_ff @(posedge clk) begin
        y_q <= y_d;
    end

    assign y = y_q;
endmodule

// File: rtl/preset_fade_scaler.sv
module preset_fade_scaler
    import pfs_pkg::*;
#(
    parameter int DW         = 16,
    parameter int SUM_W      = 18,
    parameter int RAMP_STEPS = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    src_sel,
    input  logic [2:0]              strap_preset,
    input  logic [1:0]              strap_shift,
    input  logic [2:0]              reg_preset,
    input  logic [1:0]              reg_shift,
    input  logic                    smp_stb,
    input  logic signed [SUM_W-1:0] wet_l,
    input  logic signed [SUM_W-1:0] wet_r,
    input  logic signed [DW-1:0]    dry_l,
    input  logic signed [DW-1:0]    dry_r,
    output logic signed [DW-1:0]    out_l,
    output logic signed [DW-1:0]    out_r,
    output logic [2:0]              active_preset
);
    localparam int RAMP_LOG2 = $clog2(RAMP_STEPS);
    localparam int GAIN_W    = RAMP_LOG2 + 1;
    localparam int NCH       = 2;

    logic [2:0]        want_preset;
    logic [1:0]        want_shift;
    logic [GAIN_W-1:0] fade_gain;
    phase_e            fade_phase;
    logic [1:0]        fade_phase_bits;

    logic signed [SUM_W-1:0] wet_a [NCH];
    logic signed [DW-1:0]    dry_a [NCH];
    logic signed [DW-1:0]    out_a [NCH];

    pfs_src_select u_sel (
        .src_sel      (src_sel),
        .strap_preset (strap_preset),
        .strap_shift  (strap_shift),
        .reg_preset   (reg_preset),
        .reg_shift    (reg_shift),
        .want_preset  (want_preset),
        .want_shift   (want_shift)
    );

    pfs_fade_ctrl #(
        .RAMP_STEPS (RAMP_STEPS),
        .GAIN_W     (GAIN_W)
    ) u_fade (
        .clk           (clk),
        .rst_n         (rst_n),
        .smp_stb       (smp_stb),
        .want_preset   (want_preset),
        .active_preset (active_preset),
        .gain          (fade_gain),
        .phase         (fade_phase)
    );

    assign fade_phase_bits = fade_phase;

    assign wet_a[0] = wet_l;
    assign wet_a[1] = wet_r;
    assign dry_a[0] = dry_l;
    assign dry_a[1] = dry_r;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        pfs_chan #(
            .DW        (DW),
            .SUM_W     (SUM_W),
            .GAIN_W    (GAIN_W),
            .RAMP_LOG2 (RAMP_LOG2)
        ) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .smp_stb (smp_stb),
            .wet     (wet_a[c]),
            .dry     (dry_a[c]),
            .bypass  (active_preset == PRESET_BYPASS),
            .shift   (want_shift),
            .gain    (fade_gain),
            .y       (out_a[c])
        );
    end

    assign out_l = out_a[0];
    assign out_r = out_a[1];
endmodule

// File: rtl/pfs_checker.sv
module pfs_checker #(
    parameter int DW         = 16,
    parameter int GAIN_W     = 7,
    parameter int RAMP_STEPS = 64
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 smp_stb,
    input logic [2:0]           active_preset,
    input logic [GAIN_W-1:0]    gain,
    input logic [1:0]           phase,
    input logic signed [DW-1:0] dry_l,
    input logic signed [DW-1:0] out_l,
    input logic signed [DW-1:0] out_r
);
    localparam logic [GAIN_W-1:0] FULL = GAIN_W'(RAMP_STEPS);

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_stb |=> ($stable(out_l) && $stable(out_r) && $stable(active_preset)));

    assert_swap_at_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(active_preset)) |-> ($past(gain) == '0));

    assert_gain_on_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(gain)) |-> $past(smp_stb));

    assert_gain_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        gain <= FULL);

    assert_hold_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd0) |-> (gain == FULL));

    assert_bypass_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && active_preset == 3'b111 && gain == FULL) |=> (out_l == $past(dry_l)));
endmodule

bind preset_fade_scaler pfs_checker #(
    .DW         (DW),
    .GAIN_W     (GAIN_W),
    .RAMP_STEPS (RAMP_STEPS)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .smp_stb       (smp_stb),
    .active_preset (active_preset),
    .gain          (fade_gain),
    .phase         (fade_phase_bits),
    .dry_l         (dry_l),
    .out_l         (out_l),
    .out_r         (out_r)
);

// File: tb/preset_fade_scaler_bench.sv
module preset_fade_scaler_bench;
    localparam int DW = 16;
    localparam int SUM_W = 18;
    localparam int RAMP = 64;
    localparam int RLOG = 6;

    logic clk = 0;
    logic rst_n = 0;
    logic src_sel = 0;
    logic [2:0] strap_preset = 0, reg_preset = 0;
    logic [1:0] strap_shift = 0, reg_shift = 0;
    logic smp_stb = 0;
    logic signed [SUM_W-1:0] wet_l = 0, wet_r = 0;
    logic signed [DW-1:0] dry_l = 0, dry_r = 0;
    logic signed [DW-1:0] out_l, out_r;
    logic [2:0] active_preset;

    int vectors = 0, fails = 0;
    bit done = 0;
    int m_gain, m_phase, m_active;
    logic [31:0] lfsr = 32'h1ACE_B00C;

    always #10 clk = ~clk;

    preset_fade_scaler u_preset_fade_scaler (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel),
        .strap_preset(strap_preset), .strap_shift(strap_shift),
        .reg_preset(reg_preset), .reg_shift(reg_shift),
        .smp_stb(smp_stb), .wet_l(wet_l), .wet_r(wet_r),
        .dry_l(dry_l), .dry_r(dry_r),
        .out_l(out_l), .out_r(out_r), .active_preset(active_preset)
    );

    function automatic int want_p();
        return src_sel ? int'(reg_preset) : int'(strap_preset);
    endfunction

    function automatic int want_s();
        return src_sel ? int'(reg_shift) : int'(strap_shift);
    endfunction

    function automatic int expect_ch(int wet, int dry, int sh, int g, int act);
        longint s, p;
        if (act == 7) s = dry;
        else          s = longint'(wet >>> sh);
        p = (s * g) >>> RLOG;
        if (p > 32767)  p = 32767;
        if (p < -32768) p = -32768;
        return int'(p);
    endfunction

    task automatic check(string tag, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic rnd_data();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        wet_l = lfsr[17:0];
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        wet_r = lfsr[19:2];
        dry_l = lfsr[15:0];
        dry_r = lfsr[31:16];
    endtask

    task automatic model_step();
        int w = want_p();
        case (m_phase)
            0: if (w != m_active) begin m_phase = 1; m_gain--; end
            1: if (m_gain == 0) begin m_active = w; m_phase = 2; end
               else m_gain--;
            default: begin
                if (w != m_active) begin
                    if (m_gain == 0) m_active = w;
                    else begin m_phase = 1; m_gain--; end
                end else begin
                    m_gain++;
                    if (m_gain == RAMP) m_phase = 0;
                end
            end
        endcase
    endtask

    // at a negedge: strobe once, then check outputs at the next negedge
    task automatic step(string tag);
        int el, er;
        el = expect_ch(int'(wet_l), int'(dry_l), want_s(), m_gain, m_active);
        er = expect_ch(int'(wet_r), int'(dry_r), want_s(), m_gain, m_active);
        smp_stb = 1;
        @(negedge clk);
        smp_stb = 0;
        model_step();
        check({tag, " left"}, int'(out_l), el);
        check({tag, " right"}, int'(out_r), er);
        check({tag, " preset"}, int'(active_preset), m_active);
    endtask

    task automatic do_reset();
        rst_n = 0;
        @(negedge clk);
        @(negedge clk);
        m_gain = RAMP; m_phase = 0; m_active = want_p();
        rst_n = 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R7: reset picks the strap preset, outputs cleared
        strap_preset = 3'd2; reg_preset = 3'd5;
        wet_l = 18'sd1000; dry_l = 16'sd77;
        do_reset();
        check("R7 reset preset", int'(active_preset), 2);
        check("R7 reset out_l", int'(out_l), 0);
        check("R7 reset out_r", int'(out_r), 0);

        // R3/R4: every shift code, random and extreme sums
        for (int sh = 0; sh < 4; sh++) begin
            strap_shift = 2'(sh);
            for (int k = 0; k < 24; k++) begin
                rnd_data();
                step("R3 shift sweep");
            end
            wet_l = 18'sh1FFFF; wet_r = 18'sh20000;
            step("R4 saturate extremes");
            wet_l = -18'sd3; wet_r = 18'sd32767;
            step("R3 floor rounding");
        end

        // R1: register source shift with same preset
        reg_preset = 3'd2; reg_shift = 2'd3; strap_shift = 2'd0;
        src_sel = 1;
        for (int k = 0; k < 8; k++) begin rnd_data(); step("R1 register source"); end
        // R1: strap changes ignored while register selected
        strap_preset = 3'd4;
        for (int k = 0; k < 4; k++) begin rnd_data(); step("R1 strap ignored"); end

        // R8: outputs hold without strobe
        begin
            logic signed [DW-1:0] hl, hr;
            hl = out_l; hr = out_r;
            wet_l = 18'sd5000; wet_r = -18'sd5000; reg_shift = 2'd0;
            repeat (3) @(negedge clk);
            check("R8 hold left", int'(out_l), int'(hl));
            check("R8 hold right", int'(out_r), int'(hr));
            check("R8 hold preset", int'(active_preset), 2);
        end

        // R5: full fade to preset 6 (downloaded set, R2 filtered path)
        reg_preset = 3'd6;
        for (int k = 0; k < 2 * RAMP + 4; k++) begin rnd_data(); step("R5 full fade"); end
        check("R2 downloaded preset", int'(active_preset), 6);

        // R6: change during fade-out, then again before zero
        src_sel = 0; strap_preset = 3'd1;
        for (int k = 0; k < 20; k++) begin rnd_data(); step("R6 fade-out start"); end
        strap_preset = 3'd3;
        for (int k = 0; k < 20; k++) begin rnd_data(); step("R6 mid fade-out"); end
        strap_preset = 3'd4;
        for (int k = 0; k < 40; k++) begin rnd_data(); step("R6 swap value"); end
        // R6: reversal during fade-in
        strap_preset = 3'd0;
        for (int k = 0; k < 2 * RAMP + 10; k++) begin rnd_data(); step("R6 reverse fade-in"); end
        check("R6 final preset", int'(active_preset), 0);

        // R2: bypass passes dry sample
        strap_preset = 3'd7; strap_shift = 2'd2;
        for (int k = 0; k < 2 * RAMP + 4; k++) begin rnd_data(); step("R2 enter bypass"); end
        dry_l = 16'sh8000; dry_r = 16'sh7FFF;
        step("R2 bypass dry extremes");

        // R7: reset from register source
        src_sel = 1; reg_preset = 3'd6;
        do_reset();
        check("R7 reset register preset", int'(active_preset), 6);
        rnd_data();
        step("R7 full gain after reset");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule